// File: doc/BRIEF.md
# Staged-Write Translation Buffer

This block is a small, fully associative cache of address translations. It is loaded in two steps. A page-table word is first written into a staging register, where it only waits. A later tag write commits a new entry, built from that tag, the staged word and the current address-space number. Each entry holds a physical page number, a 4-bit read-enable mask, a 4-bit write-enable mask, a fault-on-read flag, a fault-on-write flag, a global flag and a 7-bit address-space number.

A combinational lookup port gives the page number and permission bits of the entry that matches a virtual page number. Three invalidate commands are provided: invalidate every entry, invalidate every non-global entry, and invalidate one address in the current address space. A 64-bit readback word shows the most recently committed entry in a fixed layout. When a new tag is inserted, the victim slot is chosen round-robin. A parameter selects an instruction-side variant, which never grants write permission.

Top module: `xlat_buf`

## Requirements
- R1: After reset no entry is valid, every lookup misses with all lookup outputs zero, the readback word is zero, the error flag is low and the current address-space number is 0.
- R2: A write with op 0 (stage) only stores the 64-bit data. Lookups and readback do not change until a later tag write.
- R3: A write with op 1 (tag) commits an entry whose tag is data[VPN_W-1:0]. Its fields come from the staged word and the current address-space number. Both the staged word and the readback word use this layout: page number at bit 32 upward (PPN_W bits), read mask at 11:8, write mask at 15:12, fault-on-read at bit 1, fault-on-write at bit 2, global at bit 4. Staged bits 6:5 are the granularity hint. In the readback word, the address-space number sits at 63:57. An accepted commit loads the readback word.
- R4: A lookup hits when an entry is valid, its tag equals lookup_vpn_i, and either it is global or its address-space number equals the current one. On a miss, every lookup output is zero.
- R5: A tag write whose staged hint bits 6:5 are nonzero is rejected: the buffer and readback are unchanged and the error flag goes high. The next accepted tag write clears the flag.
- R6: A tag write whose tag equals a valid entry's tag overwrites that entry, so no two valid entries share a tag.
- R7: A new tag goes into the slot at the round-robin pointer, which then advances by one modulo DEPTH. The pointer is used even when other slots are invalid.
- R8: Op 3 clears every valid bit.
- R9: Op 4 clears the valid bit of every non-global entry and leaves global entries intact.
- R10: Op 5 clears the entry that matches data[VPN_W-1:0] under the lookup rule of R4 and leaves all others intact.
- R11: With IS_INSN set, the write mask of every committed entry is zero.
- R12: Op 2 loads the current address-space number from data[6:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Command strobe |
| op_i | input | 3 | Command: 0 stage, 1 tag, 2 asn, 3 flush all, 4 flush non-global, 5 flush one |
| wr_data_i | input | 64 | Command data |
| lookup_vpn_i | input | VPN_W | Virtual page number to translate |
| lookup_hit_o | output | 1 | Lookup hit |
| lookup_ppn_o | output | PPN_W | Physical page number on hit |
| lookup_rd_o | output | 4 | Read-enable mask on hit |
| lookup_wr_o | output | 4 | Write-enable mask on hit |
| lookup_for_o | output | 1 | Fault-on-read on hit |
| lookup_fow_o | output | 1 | Fault-on-write on hit |
| readback_o | output | 64 | Most recently committed entry, packed |
| gh_err_o | output | 1 | Last tag write was rejected |

## Verification
The bench targets these cases. A re-inserted tag must replace its old entry; a design that allocates a second slot shows duplicate or stale page numbers. A rejected hint must leave everything unchanged; a design that commits it anyway hits on a tag that should miss. A non-global flush must spare global entries, and a single flush must honour the current address-space number; getting either wrong makes a later lookup hit or miss against the model. The round-robin pointer must advance only on fresh allocations; if it moves on overwrites, the entry it evicts differs from the model's after a run of more than DEPTH inserts.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [2:0] {
    OP_STAGE      = 3'd0,
    OP_TAG        = 3'd1,
    OP_ASN        = 3'd2,
    OP_FLUSH_ALL  = 3'd3,
    OP_FLUSH_PROC = 3'd4,
    OP_FLUSH_ONE  = 3'd5
  } op_e;

  localparam int ASN_W   = 7;
  localparam int FR_BIT  = 1;
  localparam int FW_BIT  = 2;
  localparam int GLB_BIT = 4;
  localparam int GH_LO   = 5;
  localparam int RD_LO   = 8;
  localparam int WR_LO   = 12;
  localparam int PPN_LO  = 32;
  localparam int ASN_LO  = 57;

  typedef struct packed {
    logic [3:0]       rd;
    logic [3:0]       wr;
    logic             fr;
    logic             fw;
    logic             glb;
    logic [ASN_W-1:0] asn;
  } attr_t;
endpackage

// File: rtl/xlat_match.sv
module xlat_match
  import xlat_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int VPN_W = 20
) (
  input  logic [DEPTH-1:0]            valid_i,
  input  logic [DEPTH-1:0][VPN_W-1:0] tag_i,
  input  attr_t [DEPTH-1:0]           attr_i,
  input  logic [VPN_W-1:0]            vpn_i,
  input  logic [ASN_W-1:0]            asn_cur_i,
  input  logic                        chk_asn_i,
  output logic [DEPTH-1:0]            hit_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_o[g] = valid_i[g] && (tag_i[g] == vpn_i) &&
                      (!chk_asn_i || attr_i[g].glb || (attr_i[g].asn == asn_cur_i));
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == IDX_W'(DEPTH-1)) ? '0 : ptr_q + 1'b1;
  end
  assign ptr_o = ptr_q;

  // R7
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ptr_q) < DEPTH);
  // R7
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_q));
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
  import xlat_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 25,
  parameter bit IS_INSN = 1'b0,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       op_i,
  input  logic [63:0]      wr_data_i,
  input  logic [VPN_W-1:0] lookup_vpn_i,
  output logic             lookup_hit_o,
  output logic [PPN_W-1:0] lookup_ppn_o,
  output logic [3:0]       lookup_rd_o,
  output logic [3:0]       lookup_wr_o,
  output logic             lookup_for_o,
  output logic             lookup_fow_o,
  output logic [63:0]      readback_o,
  output logic             gh_err_o
);
  logic [DEPTH-1:0]            valid_q;
  logic [DEPTH-1:0][VPN_W-1:0] tag_q;
  logic [DEPTH-1:0][PPN_W-1:0] ppn_q;
  attr_t [DEPTH-1:0]           attr_q;
  logic [63:0]                 stage_q, rb_q;
  logic [ASN_W-1:0]            asn_cur_q;
  logic                        err_q;

  op_e op;
  assign op = op_e'(op_i);

  logic do_stage, do_tag, do_asn, do_all, do_proc, do_one;
  assign do_stage = wr_en_i && (op == OP_STAGE);
  assign do_tag   = wr_en_i && (op == OP_TAG);
  assign do_asn   = wr_en_i && (op == OP_ASN);
  assign do_all   = wr_en_i && (op == OP_FLUSH_ALL);
  assign do_proc  = wr_en_i && (op == OP_FLUSH_PROC);
  assign do_one   = wr_en_i && (op == OP_FLUSH_ONE);

  logic gh_bad, ins_ok, ins_bad;
  assign gh_bad  = |stage_q[GH_LO +: 2];
  assign ins_ok  = do_tag && !gh_bad;
  assign ins_bad = do_tag && gh_bad;

  // command-side compare: tag only for inserts, tag+asn for single flush
  logic [DEPTH-1:0] cmd_hits, look_hits;
  xlat_match #(.DEPTH(DEPTH), .VPN_W(VPN_W)) u_cmd_match (
    .valid_i(valid_q), .tag_i(tag_q), .attr_i(attr_q),
    .vpn_i(wr_data_i[VPN_W-1:0]), .asn_cur_i(asn_cur_q),
    .chk_asn_i(do_one), .hit_o(cmd_hits)
  );
  xlat_match #(.DEPTH(DEPTH), .VPN_W(VPN_W)) u_look_match (
    .valid_i(valid_q), .tag_i(tag_q), .attr_i(attr_q),
    .vpn_i(lookup_vpn_i), .asn_cur_i(asn_cur_q),
    .chk_asn_i(1'b1), .hit_o(look_hits)
  );

  logic             dup;
  logic [IDX_W-1:0] dup_idx, ptr, slot;
  assign dup = |cmd_hits;
  always_comb begin
    dup_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (cmd_hits[i]) dup_idx = IDX_W'(i);
  end

  xlat_victim #(.DEPTH(DEPTH)) u_victim (
    .clk_i, .rst_ni, .adv_i(ins_ok && !dup), .ptr_o(ptr)
  );
  assign slot = dup ? dup_idx : ptr;

  attr_t            new_attr;
  logic [PPN_W-1:0] new_ppn;
  always_comb begin
    new_ppn      = stage_q[PPN_LO +: PPN_W];
    new_attr.rd  = stage_q[RD_LO +: 4];
    new_attr.wr  = IS_INSN ? 4'h0 : stage_q[WR_LO +: 4];
    new_attr.fr  = stage_q[FR_BIT];
    new_attr.fw  = stage_q[FW_BIT];
    new_attr.glb = stage_q[GLB_BIT];
    new_attr.asn = asn_cur_q;
  end

  logic [63:0] new_rb;
  always_comb begin
    new_rb                   = '0;
    new_rb[PPN_LO +: PPN_W]  = new_ppn;
    new_rb[RD_LO +: 4]       = new_attr.rd;
    new_rb[WR_LO +: 4]       = new_attr.wr;
    new_rb[FR_BIT]           = new_attr.fr;
    new_rb[FW_BIT]           = new_attr.fw;
    new_rb[GLB_BIT]          = new_attr.glb;
    new_rb[ASN_LO +: ASN_W]  = new_attr.asn;
  end

  logic [DEPTH-1:0] glb_vec;
  for (genvar g = 0; g < DEPTH; g++) begin : g_glb
    assign glb_vec[g] = attr_q[g].glb;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= '0;
      tag_q     <= '0;
      ppn_q     <= '0;
      attr_q    <= '0;
      stage_q   <= '0;
      rb_q      <= '0;
      asn_cur_q <= '0;
      err_q     <= 1'b0;
    end else begin
      if (do_stage) stage_q   <= wr_data_i;
      if (do_asn)   asn_cur_q <= wr_data_i[ASN_W-1:0];
      if (ins_bad)  err_q     <= 1'b1;
      if (ins_ok) begin
        valid_q[slot] <= 1'b1;
        tag_q[slot]   <= wr_data_i[VPN_W-1:0];
        ppn_q[slot]   <= new_ppn;
        attr_q[slot]  <= new_attr;
        rb_q          <= new_rb;
        err_q         <= 1'b0;
      end
      if (do_all)  valid_q <= '0;
      if (do_proc) valid_q <= valid_q & glb_vec;
      if (do_one)  valid_q <= valid_q & ~cmd_hits;
    end
  end

  always_comb begin
    lookup_hit_o = |look_hits;
    lookup_ppn_o = '0;
    lookup_rd_o  = '0;
    lookup_wr_o  = '0;
    lookup_for_o = 1'b0;
    lookup_fow_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (look_hits[i]) begin
        lookup_ppn_o = lookup_ppn_o | ppn_q[i];
        lookup_rd_o  = lookup_rd_o  | attr_q[i].rd;
        lookup_wr_o  = lookup_wr_o  | attr_q[i].wr;
        lookup_for_o = lookup_for_o | attr_q[i].fr;
        lookup_fow_o = lookup_fow_o | attr_q[i].fw;
      end
    end
  end

  assign readback_o = rb_q;
  assign gh_err_o   = err_q;

  // R6
  no_dup_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(look_hits));
  // R5
  gh_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_bad |=> gh_err_o && $stable(valid_q) && $stable(readback_o));
  // R3
  rb_asn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_ok |=> (readback_o[ASN_LO +: ASN_W] == $past(asn_cur_q)) && !gh_err_o);
  // R8
  flush_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_all |=> (valid_q == '0));
  // R9
  flush_proc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_proc |=> ((valid_q & ~glb_vec) == '0));
  // R2
  stage_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_stage |=> $stable(valid_q) && $stable(readback_o));
  // R11
  insn_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (IS_INSN && lookup_hit_o) |-> (lookup_wr_o == 4'h0));
endmodule

// File: tb/xlat_buf_tb.sv
`timescale 1ns/1ps
module xlat_buf_tb;
  localparam int DEPTH = 8;
  localparam int VPN_W = 20;
  localparam int PPN_W = 25;

  logic clk = 1'b0, rst_ni = 1'b0, wr_en = 1'b0;
  logic [2:0] op = '0;
  logic [63:0] wdata = '0;
  logic [VPN_W-1:0] lvpn = '0;
  logic hit, for_b, fow_b, err, hit_i, for_i, fow_i, err_i;
  logic [PPN_W-1:0] ppn, ppn_i;
  logic [3:0] rd, wr, rd_i, wr_i;
  logic [63:0] rb, rb_i;

  always #2.5 clk = ~clk;

  xlat_buf #(.DEPTH(DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W), .IS_INSN(1'b0)) u_dut (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .op_i(op), .wr_data_i(wdata),
    .lookup_vpn_i(lvpn), .lookup_hit_o(hit), .lookup_ppn_o(ppn), .lookup_rd_o(rd),
    .lookup_wr_o(wr), .lookup_for_o(for_b), .lookup_fow_o(fow_b),
    .readback_o(rb), .gh_err_o(err));
  xlat_buf #(.DEPTH(DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W), .IS_INSN(1'b1)) u_dut_i (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .op_i(op), .wr_data_i(wdata),
    .lookup_vpn_i(lvpn), .lookup_hit_o(hit_i), .lookup_ppn_o(ppn_i), .lookup_rd_o(rd_i),
    .lookup_wr_o(wr_i), .lookup_for_o(for_i), .lookup_fow_o(fow_i),
    .readback_o(rb_i), .gh_err_o(err_i));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model
  bit          m_v[DEPTH];
  int          m_tag[DEPTH];
  logic [PPN_W-1:0] m_ppn[DEPTH];
  logic [3:0]  m_rd[DEPTH], m_wr[DEPTH];
  bit          m_fr[DEPTH], m_fw[DEPTH], m_g[DEPTH];
  int          m_asn[DEPTH];
  int          m_ptr = 0, m_cur = 0;
  logic [63:0] m_stage = '0, m_rb = '0;
  bit          m_err = 1'b0;

  function automatic logic [63:0] mk_pte(logic [PPN_W-1:0] p, logic [3:0] r, logic [3:0] w,
                                         bit fr, bit fw, bit g, logic [1:0] gh);
    logic [63:0] x = '0;
    x[32 +: PPN_W] = p; x[11:8] = r; x[15:12] = w;
    x[1] = fr; x[2] = fw; x[4] = g; x[6:5] = gh;
    return x;
  endfunction

  function automatic int m_find(int vpn, bit use_asn);
    for (int i = 0; i < DEPTH; i++)
      if (m_v[i] && m_tag[i] == vpn && (!use_asn || m_g[i] || m_asn[i] == m_cur)) return i;
    return -1;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic m_apply(int o, logic [63:0] d);
    int k, s;
    case (o)
      0: m_stage = d;
      1: if (m_stage[6:5] != 0) m_err = 1'b1;
         else begin
           k = m_find(int'(d[VPN_W-1:0]), 1'b0);
           if (k >= 0) s = k;
           else begin s = m_ptr; m_ptr = (m_ptr + 1) % DEPTH; end
           m_v[s] = 1; m_tag[s] = int'(d[VPN_W-1:0]);
           m_ppn[s] = m_stage[32 +: PPN_W]; m_rd[s] = m_stage[11:8]; m_wr[s] = m_stage[15:12];
           m_fr[s] = m_stage[1]; m_fw[s] = m_stage[2]; m_g[s] = m_stage[4]; m_asn[s] = m_cur;
           m_rb = m_stage & ~64'h0000_0000_0000_0060;
           m_rb[63:57] = 7'(m_cur);
           m_err = 1'b0;
         end
      2: m_cur = int'(d[6:0]);
      3: for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
      4: for (int i = 0; i < DEPTH; i++) if (!m_g[i]) m_v[i] = 0;
      5: begin k = m_find(int'(d[VPN_W-1:0]), 1'b1); if (k >= 0) m_v[k] = 0; end
      default: ;
    endcase
  endtask

  task automatic do_op(int o, logic [63:0] d);
    @(negedge clk);
    op = 3'(o); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    m_apply(o, d);
  endtask

  task automatic chk_look(string req, int vpn);
    int k;
    logic [63:0] exp = '0;
    lvpn = VPN_W'(vpn);
    #0.5;
    k = m_find(vpn, 1'b1);
    if (k >= 0) exp = {28'd0, 1'b1, m_ppn[k], m_rd[k], m_wr[k], m_fr[k], m_fw[k]};
    chk(req, {28'd0, hit, ppn, rd, wr, for_b, fow_b}, exp);
    chk("R11", {58'd0, hit_i, wr_i, ppn_i == ppn}, {58'd0, exp[35], 4'h0, 1'b1});
  endtask

  task automatic chk_state(string req);
    chk(req, rb, m_rb);
    chk(req, {63'd0, err}, {63'd0, m_err});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_g[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_state("R1");
    chk_look("R1", 0);
    // R12 current asn from low 7 bits
    do_op(2, 64'h83);
    do_op(0, mk_pte(25'h12345, 4'h3, 4'h5, 1, 0, 0, 0));
    // R2 staging alone changes nothing
    chk_look("R2", 5);
    chk_state("R2");
    do_op(1, 64'h5);
    // R3 commit and readback layout
    chk_look("R3", 5);
    chk("R3", rb, {7'd3, 25'h12345, 16'h0, 4'h5, 4'h3, 8'h02});
    // R12/R4 asn mismatch misses
    do_op(2, 64'h4);
    chk_look("R12", 5);
    do_op(0, mk_pte(25'h777, 4'hf, 4'h1, 0, 1, 1, 0));
    do_op(1, 64'h6);
    do_op(2, 64'h9);
    chk_look("R4", 6);
    chk_look("R4", 5);
    // R5 hint rejection
    do_op(0, mk_pte(25'h1, 4'h1, 4'h1, 0, 0, 0, 2'd2));
    do_op(1, 64'h7);
    chk_state("R5");
    chk_look("R5", 7);
    do_op(0, mk_pte(25'h2, 4'h2, 4'h2, 0, 0, 1, 0));
    do_op(1, 64'h7);
    chk_state("R5");
    // R6 overwrite on same tag
    do_op(0, mk_pte(25'h3, 4'h4, 4'h8, 1, 1, 1, 0));
    do_op(1, 64'h7);
    chk_look("R6", 7);
    // R8 flush all
    do_op(3, 64'h0);
    chk_look("R8", 6);
    chk_look("R8", 7);
    // R7 round robin eviction
    for (int t = 20; t < 20 + DEPTH + 1; t++) begin
      do_op(0, mk_pte(25'(t), 4'h1, 4'h0, 0, 0, 0, 0));
      do_op(1, 64'(t));
    end
    chk_look("R7", 20);
    chk_look("R7", 21);
    chk_look("R7", 20 + DEPTH);
    // R9 flush non-global
    do_op(0, mk_pte(25'h30, 4'h1, 4'h1, 0, 0, 1, 0)); do_op(1, 64'd30);
    do_op(0, mk_pte(25'h31, 4'h1, 4'h1, 0, 0, 0, 0)); do_op(1, 64'd31);
    do_op(4, 64'h0);
    chk_look("R9", 30);
    chk_look("R9", 31);
    // R10 single flush honours asn
    do_op(0, mk_pte(25'h40, 4'h1, 4'h1, 0, 0, 0, 0)); do_op(1, 64'd40);
    do_op(0, mk_pte(25'h41, 4'h1, 4'h1, 0, 0, 0, 0)); do_op(1, 64'd41);
    do_op(2, 64'h2);
    do_op(5, 64'd41);
    do_op(2, 64'h9);
    chk_look("R10", 41);
    do_op(5, 64'd40);
    chk_look("R10", 40);
    chk_look("R10", 41);
    // random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      int r, o;
      logic [63:0] d;
      r = int'($urandom_range(0, 99));
      o = (r < 35) ? 0 : (r < 70) ? 1 : (r < 80) ? 2 : (r < 84) ? 3 : (r < 90) ? 4 : 5;
      if (o == 0)
        d = mk_pte(25'($urandom), 4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'd0);
      else if (o == 2) d = 64'($urandom_range(0, 3));
      else d = 64'($urandom_range(0, 11));
      do_op(o, d);
      chk_state("R5");
      for (int v = 0; v < 12; v++) chk_look("R4", v);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule